// File: doc/BRIEF.md
# Paged Memory Mapping Unit

This block extends the 16-bit address of an 8-bit processor to a larger physical memory. It divides the 64 KB logical space into four 16 KB pages, picked by the two top logical address lines. Each page holds a 4-bit bank number, and that number becomes the four extended address lines. The extended lines therefore address sixteen 16 KB physical banks. The top extended line chooses the memory type. Banks 0 to 7 live in ROM and banks 8 to 15 live in RAM. The block drives separate active-low enables for the two memories.

Software programs the map through one byte-wide I/O port. A single write names the page to update, gives the new bank number, and sets or clears a boot flag. Reset sets the boot flag. While the flag is set, the extended address is forced to the top ROM bank, so the processor fetches its start-up code from there in every page. Software fills in the four page entries and then clears the flag with its last write, which switches on mapped operation. Reset does not clear the page entries.

The page lookup is combinational, so a memory cycle sees no extra latency. A table write is registered on the rising clock edge that samples the write strobe.

Top module: `page_map_unit`

## Requirements
- R1: In mapped mode, `ext_addr` equals the bank stored for the page that `page_sel` names (page_sel = logical A15:A14).
- R2: The write byte is decoded as follows. Bit 7 is the boot flag. Bits 5:4 are the page index, with bit 5 the high bit. Bits 3:0 are the bank number, with bit 3 the high extended line. Bit 6 has no effect.
- R3: A write is taken at a rising clock edge only when `io_sel`, `io_req` and `io_wr` are all high. If any one of them is low, neither the table nor the boot flag changes.
- R4: Reset (synchronous, active high) sets the boot flag. The page entries keep their contents through reset.
- R5: While the boot flag is set, `ext_addr` is 4'h7 (the top ROM bank), whatever the page and the table hold.
- R6: Every accepted write loads the boot flag from data bit 7. A 1 keeps or enters boot mode, and a 0 enables mapped operation.
- R7: When `mem_req` is high and ext_addr[3] is 0, `rom_cs_n` is low and `ram_cs_n` is high. When ext_addr[3] is 1, the two are swapped. When `mem_req` is low, both enables are high.
- R8: `ext_addr` follows `page_sel` in the same cycle. A write becomes visible only after the edge that samples it, and before that edge the old bank is still output.
- R9: A write to one page leaves the other three entries unchanged.
- R10: A write strobe that arrives in a cycle where reset is high is discarded. The boot flag ends up set and the table entry keeps its old value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| io_sel | input | 1 | Port address matches the mapping port |
| io_req | input | 1 | I/O request active (high) |
| io_wr | input | 1 | Write strobe active (high) |
| io_data | input | 8 | Write data byte |
| page_sel | input | 2 | Logical address bits 15:14 |
| mem_req | input | 1 | Memory request active (high) |
| ext_addr | output | 4 | Physical address bits 17:14 |
| rom_cs_n | output | 1 | ROM enable, active low |
| ram_cs_n | output | 1 | RAM enable, active low |

## Verification
A table update and a lookup can fall in the same cycle. The bench provokes this by holding `page_sel` on the page being rewritten while the write strobe is high. It expects the old bank before the sampling edge and the new bank after it. A reset and a write strobe can also coincide. In that case the bench expects boot mode afterwards, and then checks that the entry still holds its earlier bank once mapped mode is enabled through a write to a different page.

// File: rtl/pmu_pkg.sv
package pmu_pkg;
  localparam int PMU_DATA_W   = 8;
  localparam int PMU_PAGE_W   = 2;
  localparam int PMU_BANK_W   = 4;
  localparam int PMU_PAGES    = 1 << PMU_PAGE_W;
  // field positions within the control byte
  localparam int PMU_FLAG_POS = 7;
  localparam int PMU_PAGE_LSB = 4;
  localparam int PMU_BANK_LSB = 0;

  typedef logic [PMU_BANK_W-1:0] bank_t;
  typedef logic [PMU_PAGE_W-1:0] page_t;

  typedef struct packed {
    logic  boot;
    page_t page;
    bank_t bank;
  } map_cmd_t;
endpackage

// File: rtl/pmu_port_decode.sv
module pmu_port_decode
  import pmu_pkg::*;
(
  input  logic                  rst,
  input  logic                  io_sel,
  input  logic                  io_req,
  input  logic                  io_wr,
  input  logic [PMU_DATA_W-1:0] io_data,
  output logic                  wr_hit,
  output map_cmd_t              cmd
);
  // a strobe seen during reset is dropped
  assign wr_hit   = io_sel & io_req & io_wr & ~rst;
  assign cmd.boot = io_data[PMU_FLAG_POS];
  assign cmd.page = io_data[PMU_PAGE_LSB +: PMU_PAGE_W];
  assign cmd.bank = io_data[PMU_BANK_LSB +: PMU_BANK_W];
endmodule

// File: rtl/pmu_page_table.sv
module pmu_page_table
  import pmu_pkg::*;
#(
  parameter int PAGES = PMU_PAGES
) (
  input  logic  clk,
  input  logic  we,
  input  page_t wr_page,
  input  bank_t wr_bank,
  input  page_t rd_page,
  output bank_t rd_bank
);
  bank_t entry_q [PAGES];

  // entries carry no reset; each one loads only on its own index
  for (genvar g = 0; g < PAGES; g++) begin : g_entry
    always_ff @(posedge clk) begin
      if (we && (wr_page == page_t'(g))) entry_q[g] <= wr_bank;
    end
  end

  assign rd_bank = entry_q[rd_page];
endmodule

// File: rtl/pmu_boot_ctl.sv
module pmu_boot_ctl (
  input  logic clk,
  input  logic rst,
  input  logic wr_hit,
  input  logic wr_boot,
  output logic boot_q
);
  always_ff @(posedge clk) begin
    if (rst)         boot_q <= 1'b1;
    else if (wr_hit) boot_q <= wr_boot;
  end
endmodule

// File: rtl/pmu_chip_sel.sv
module pmu_chip_sel
  import pmu_pkg::*;
#(
  parameter bank_t BOOT_BANK = 4'h7
) (
  input  logic  boot_q,
  input  bank_t table_bank,
  input  logic  mem_req,
  output bank_t ext_addr,
  output logic  rom_cs_n,
  output logic  ram_cs_n
);
  localparam int TYPE_BIT = PMU_BANK_W - 1;

  logic use_ram;

  assign ext_addr = boot_q ? BOOT_BANK : table_bank;
  assign use_ram  = ext_addr[TYPE_BIT];
  assign rom_cs_n = ~(mem_req & ~use_ram);
  assign ram_cs_n = ~(mem_req &  use_ram);
endmodule

// File: rtl/page_map_unit.sv
module page_map_unit
  import pmu_pkg::*;
#(
  parameter bank_t BOOT_BANK = 4'h7
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  io_sel,
  input  logic                  io_req,
  input  logic                  io_wr,
  input  logic [PMU_DATA_W-1:0] io_data,
  input  logic [PMU_PAGE_W-1:0] page_sel,
  input  logic                  mem_req,
  output logic [PMU_BANK_W-1:0] ext_addr,
  output logic                  rom_cs_n,
  output logic                  ram_cs_n
);
  logic     wr_hit;
  map_cmd_t cmd;
  logic     boot_q;
  bank_t    table_bank;

  pmu_port_decode u_dec (
    .rst     (rst),
    .io_sel  (io_sel),
    .io_req  (io_req),
    .io_wr   (io_wr),
    .io_data (io_data),
    .wr_hit  (wr_hit),
    .cmd     (cmd)
  );

  pmu_page_table #(.PAGES(PMU_PAGES)) u_tbl (
    .clk     (clk),
    .we      (wr_hit),
    .wr_page (cmd.page),
    .wr_bank (cmd.bank),
    .rd_page (page_sel),
    .rd_bank (table_bank)
  );

  pmu_boot_ctl u_boot (
    .clk     (clk),
    .rst     (rst),
    .wr_hit  (wr_hit),
    .wr_boot (cmd.boot),
    .boot_q  (boot_q)
  );

  pmu_chip_sel #(.BOOT_BANK(BOOT_BANK)) u_cs (
    .boot_q     (boot_q),
    .table_bank (table_bank),
    .mem_req    (mem_req),
    .ext_addr   (ext_addr),
    .rom_cs_n   (rom_cs_n),
    .ram_cs_n   (ram_cs_n)
  );
endmodule

// File: rtl/pmu_checker.sv
module pmu_checker
  import pmu_pkg::*;
#(
  parameter bank_t BOOT_BANK = 4'h7
) (
  input logic  clk,
  input logic  rst,
  input logic  wr_hit,
  input logic  wr_boot,
  input logic  boot_q,
  input logic  mem_req,
  input bank_t ext_addr,
  input logic  rom_cs_n,
  input logic  ram_cs_n
);
  assert_reset_boot_R4: assert property (@(posedge clk) rst |=> boot_q);

  assert_boot_default_R5: assert property (@(posedge clk) disable iff (rst)
    boot_q |-> (ext_addr == BOOT_BANK));

  assert_flag_load_R6: assert property (@(posedge clk) disable iff (rst)
    wr_hit |=> (boot_q == $past(wr_boot)));

  assert_flag_hold_R3: assert property (@(posedge clk) disable iff (rst)
    !wr_hit |=> $stable(boot_q));

  assert_one_enable_R7: assert property (@(posedge clk) disable iff (rst)
    mem_req |-> (rom_cs_n != ram_cs_n));

  assert_idle_enables_R7: assert property (@(posedge clk) disable iff (rst)
    !mem_req |-> (rom_cs_n && ram_cs_n));
endmodule

bind page_map_unit pmu_checker #(.BOOT_BANK(BOOT_BANK)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .wr_hit   (wr_hit),
  .wr_boot  (cmd.boot),
  .boot_q   (boot_q),
  .mem_req  (mem_req),
  .ext_addr (ext_addr),
  .rom_cs_n (rom_cs_n),
  .ram_cs_n (ram_cs_n)
);

// File: tb/tb_page_map_unit.sv
module tb_page_map_unit;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       io_sel = 1'b0, io_req = 1'b0, io_wr = 1'b0;
  logic [7:0] io_data = 8'h00;
  logic [1:0] page_sel = 2'd0;
  logic       mem_req = 1'b0;
  logic [3:0] ext_addr;
  logic       rom_cs_n, ram_cs_n;

  always #4 clk = ~clk;  // 125 MHz

  page_map_unit dut (
    .clk(clk), .rst(rst), .io_sel(io_sel), .io_req(io_req), .io_wr(io_wr),
    .io_data(io_data), .page_sel(page_sel), .mem_req(mem_req),
    .ext_addr(ext_addr), .rom_cs_n(rom_cs_n), .ram_cs_n(ram_cs_n)
  );

  // reference model built from the requirements
  logic [3:0] bank_m [4];
  logic       boot_m = 1'b1;
  localparam logic [3:0] BOOT_EXP = 4'h7;

  typedef struct {
    string      tag;
    logic [3:0] ea;
    logic       rom_n;
    logic       ram_n;
  } exp_t;

  exp_t sb[$];
  event ev_probe;
  int   n_chk = 0;
  int   n_bad = 0;
  bit   done  = 1'b0;

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  endtask

  // monitor: pops expected items and compares against the ports
  initial begin
    forever begin
      @(ev_probe);
      while (sb.size() > 0) begin
        exp_t e;
        e = sb.pop_front();
        n_chk++;
        if (ext_addr !== e.ea || rom_cs_n !== e.rom_n || ram_cs_n !== e.ram_n) begin
          n_bad++;
          $display("FAIL %s: got ea=%h rom_n=%b ram_n=%b, expected ea=%h rom_n=%b ram_n=%b",
                   e.tag, ext_addr, rom_cs_n, ram_cs_n, e.ea, e.rom_n, e.ram_n);
        end
      end
    end
  end

  // driver: applies a lookup and pushes the expected result
  task automatic probe(input logic [1:0] pg, input logic mr, input string tag);
    exp_t e;
    page_sel = pg;
    mem_req  = mr;
    #1;
    e.tag   = tag;
    e.ea    = boot_m ? BOOT_EXP : bank_m[pg];
    e.rom_n = !(mr && !e.ea[3]);
    e.ram_n = !(mr &&  e.ea[3]);
    sb.push_back(e);
    -> ev_probe;
    #1;
  endtask

  task automatic io_write(input logic [7:0] d, input logic s = 1'b1,
                          input logic q = 1'b1, input logic w = 1'b1);
    @(negedge clk);
    io_data = d; io_sel = s; io_req = q; io_wr = w;
    @(posedge clk);
    if (s && q && w && !rst) begin
      boot_m = d[7];
      bank_m[d[5:4]] = d[3:0];
    end
    @(negedge clk);
    io_sel = 1'b0; io_req = 1'b0; io_wr = 1'b0;
  endtask

  task automatic probe_all(input string tag);
    for (int p = 0; p < 4; p++) probe(2'(p), 1'b1, tag);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: got no completion, expected end of test");
      finish_run();
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);

    // R4 R5 R7: reset state, boot bank in every page, ROM enabled
    probe_all("R4_R5 reset default");
    probe(2'd2, 1'b0, "R7 idle enables");

    // boot sequence; bit 6 set on one write (R2), flag held by bit 7 (R6)
    io_write(8'h82);
    probe(2'd0, 1'b1, "R6 still boot after 0x82");
    io_write(8'h99);
    io_write(8'hEA);
    probe(2'd3, 1'b1, "R5 boot forces default");
    io_write(8'h3B);
    probe_all("R1_R2 boot sequence mapping");
    probe(2'd1, 1'b0, "R7 idle in mapped mode");

    // R3: one qualifier missing each time
    io_write(8'h07, 1'b0, 1'b1, 1'b1);
    io_write(8'h87, 1'b1, 1'b0, 1'b1);
    io_write(8'h87, 1'b1, 1'b1, 1'b0);
    probe_all("R3 unqualified writes ignored");

    // R9: remap one page
    io_write(8'h25);
    probe_all("R9 single page remap");

    // R8: write to the page under lookup
    @(negedge clk);
    page_sel = 2'd1; mem_req = 1'b1;
    io_data = 8'h1C; io_sel = 1'b1; io_req = 1'b1; io_wr = 1'b1;
    probe(2'd1, 1'b1, "R8 old bank before edge");
    @(posedge clk);
    boot_m = 1'b0; bank_m[1] = 4'hC;
    #2;
    probe(2'd1, 1'b1, "R8 new bank after edge");
    @(negedge clk);
    io_sel = 1'b0; io_req = 1'b0; io_wr = 1'b0;

    // R6: re-enter boot mode, then leave it
    io_write(8'h81);
    probe(2'd2, 1'b1, "R6 boot re-entered");
    io_write(8'h01);
    probe_all("R6 mapped again");

    // R4: entries survive reset
    @(negedge clk); rst = 1'b1; boot_m = 1'b1;
    @(negedge clk); @(negedge clk);
    probe(2'd1, 1'b1, "R4 boot during reset");
    rst = 1'b0;
    io_write(8'h3D);
    probe_all("R4 entries kept through reset");

    // R10: write coincident with reset is discarded
    @(negedge clk);
    rst = 1'b1; boot_m = 1'b1;
    io_data = 8'h06; io_sel = 1'b1; io_req = 1'b1; io_wr = 1'b1;
    @(negedge clk);
    io_sel = 1'b0; io_req = 1'b0; io_wr = 1'b0;
    rst = 1'b0;
    @(negedge clk);
    probe(2'd0, 1'b1, "R10 boot after reset with write");
    io_write(8'h3E);
    probe_all("R10 entry untouched by write in reset");

    done = 1'b1;
    repeat (2) @(negedge clk);
    finish_run();
  end
endmodule